// File: doc/BRIEF.md
# SPI to Register Bus Bridge

This block is an SPI slave that lets an external host read and write a 32-bit register space. Each SPI frame, bounded by chip select, carries a four-byte header (an opcode, a 16-bit start address and a word count) followed by that many 32-bit data words. Write frames deliver words on MOSI; read frames return words on MISO. Inside the chip the bridge acts as master on a simple request/acknowledge register bus.

The SPI pins are brought into the system clock domain through two-flop synchronizers, and the bridge detects the serial clock edges there. The serial clock must therefore be well below the system clock. In a burst the bus address advances by one word (4 bytes) per word. For reads the first word is fetched as soon as the header completes. Each later word is fetched while the word before it is still shifting out. Framing faults raise a sticky error flag that the host clears through a dedicated input.

Top module: `spi_regbus_bridge`

## Requirements
- R1: The serial interface is SPI mode 0: the clock idles low, MOSI is sampled on its rising edge and MISO changes after its falling edge. Bytes and 32-bit words travel most significant bit first.
- R2: A first byte of 0x61 opens a write frame and 0x41 opens a read frame.
- R3: The second and third bytes form the 16-bit start address, high byte first, and the fourth byte is the number of 32-bit words to transfer.
- R4: Within one chip-select assertion, word n of a burst uses bus address start + 4·n.
- R5: In a read frame the bus read of the first word is issued once the header is complete, and each word's bits appear on MISO in time for the host to sample them on the rising clock edges of that word.
- R6: If chip select rises before the declared word count is reached, or in the middle of a byte, the error flag is set and no incomplete word is written to the bus.
- R7: A first byte other than 0x61 or 0x41 sets the error flag, and the rest of that frame causes no bus access.
- R8: The error flag stays set until `err_clr` is asserted. A new error in the same cycle takes priority over the clear.
- R9: Once `bus_req` rises it stays high, with address, write data and direction stable, until the cycle in which `bus_ack` is high. It then drops.
- R10: Serial clocks after the declared word count set the error flag and cause no further bus access.
- R11: A frame with a word count of zero makes no bus access and raises no error.
- R12: After reset the error flag, `bus_req` and `miso` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_req | output | 1 | Register bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid while bus_ack is high |
| bus_ack | input | 1 | Access complete |
| err_clr | input | 1 | Clears the framing error flag |
| err_flag | output | 1 | Sticky framing error flag |

## Verification
The bench builds the bridge with its defaults: a 16-bit address, 32-bit words, an 8-bit word count and two synchronizer stages. The serial clock runs at one twentieth of the system clock, which leaves a random 1-to-3-cycle bus latency well within the half bit time. With a 64-word register model behind the bus and addresses that have a nonzero high byte, the tests cover full burst lengths, address carry into the high byte, truncated words and overrun frames.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam logic [7:0] OP_WRITE = 8'h61;
  localparam logic [7:0] OP_READ  = 8'h41;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WR,
    ST_RD,
    ST_SKIP
  } frame_state_t;

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_bridge_frame.sv
module spi_bridge_frame
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic              cmd_we,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              tx_bit,
  output logic              err_set
);

  localparam int HDR_BITS = 8 + ADDR_W + CNT_W;
  localparam int BIT_MAX  = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int BC_W     = $clog2(BIT_MAX);
  localparam int STEP     = DATA_W / 8;
  localparam logic [BC_W-1:0]   LAST_HDR  = BC_W'(HDR_BITS - 1);
  localparam logic [BC_W-1:0]   LAST_WORD = BC_W'(DATA_W - 1);
  localparam logic [BC_W-1:0]   LAST_BYTE = BC_W'(7);
  localparam logic [ADDR_W-1:0] ADDR_INC  = ADDR_W'(STEP);

  frame_state_t       state;
  logic               sclk_q, cs_q;
  logic [BC_W-1:0]    bitcnt;
  logic [BIT_MAX-1:0] sr_in;
  logic [ADDR_W-1:0]  cur_addr;
  logic [CNT_W-1:0]   word_cnt, words_done;
  logic [DATA_W-1:0]  tx_sr, prefetch;
  logic               first_pend;

  logic               sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [BIT_MAX-1:0] sr_next;
  logic [7:0]         first_byte, hdr_op;
  logic [ADDR_W-1:0]  hdr_addr;
  logic [CNT_W-1:0]   hdr_cnt;
  logic [CNT_W:0]     next_done;
  logic               in_data, op_ok, overrun, more_words;

  assign sclk_rise  = sclk_s & ~sclk_q;
  assign sclk_fall  = ~sclk_s & sclk_q;
  assign cs_fall    = ~cs_n_s & cs_q;
  assign cs_rise    = cs_n_s & ~cs_q;
  assign sr_next    = {sr_in[BIT_MAX-2:0], mosi_s};
  assign first_byte = sr_next[7:0];
  assign hdr_op     = sr_next[HDR_BITS-1 -: 8];
  assign hdr_addr   = sr_next[CNT_W +: ADDR_W];
  assign hdr_cnt    = sr_next[CNT_W-1:0];
  assign op_ok      = (first_byte == OP_WRITE) || (first_byte == OP_READ);
  assign in_data    = (state == ST_WR) || (state == ST_RD);
  assign overrun    = (words_done == word_cnt);
  assign next_done  = {1'b0, words_done} + (CNT_W+1)'(1);
  assign more_words = next_done < {1'b0, word_cnt};
  assign tx_bit     = tx_sr[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      bitcnt     <= '0;
      sr_in      <= '0;
      cur_addr   <= '0;
      word_cnt   <= '0;
      words_done <= '0;
      tx_sr      <= '0;
      prefetch   <= '0;
      first_pend <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_we     <= 1'b0;
      cmd_addr   <= '0;
      cmd_wdata  <= '0;
      err_set    <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      cs_q      <= cs_n_s;
      cmd_valid <= 1'b0;
      err_set   <= 1'b0;

      if (rd_valid) begin
        if (first_pend) begin
          tx_sr      <= rd_data;
          first_pend <= 1'b0;
        end else begin
          prefetch <= rd_data;
        end
      end

      if (cs_fall) begin
        state      <= ST_HDR;
        bitcnt     <= '0;
        words_done <= '0;
        tx_sr      <= '0;
        first_pend <= 1'b0;
      end else if (cs_rise) begin
        if ((state == ST_HDR && bitcnt != '0) ||
            (in_data && (bitcnt != '0 || !overrun)))
          err_set <= 1'b1;
        state <= ST_IDLE;
        tx_sr <= '0;
      end else if (sclk_rise && state != ST_IDLE && state != ST_SKIP) begin
        sr_in  <= sr_next;
        bitcnt <= bitcnt + 1'b1;
        unique case (state)
          ST_HDR: begin
            if (bitcnt == LAST_BYTE && !op_ok) begin
              state   <= ST_SKIP;
              err_set <= 1'b1;
            end else if (bitcnt == LAST_HDR) begin
              bitcnt   <= '0;
              cur_addr <= hdr_addr;
              word_cnt <= hdr_cnt;
              if (hdr_op == OP_READ) begin
                state <= ST_RD;
                if (hdr_cnt != '0) begin
                  cmd_valid  <= 1'b1;
                  cmd_we     <= 1'b0;
                  cmd_addr   <= hdr_addr;
                  first_pend <= 1'b1;
                end
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (overrun) begin
              state   <= ST_SKIP;
              err_set <= 1'b1;
            end else if (bitcnt == LAST_WORD) begin
              bitcnt     <= '0;
              cmd_valid  <= 1'b1;
              cmd_we     <= 1'b1;
              cmd_addr   <= cur_addr;
              cmd_wdata  <= sr_next[DATA_W-1:0];
              cur_addr   <= cur_addr + ADDR_INC;
              words_done <= next_done[CNT_W-1:0];
            end
          end
          ST_RD: begin
            if (overrun) begin
              state   <= ST_SKIP;
              err_set <= 1'b1;
            end else begin
              if (bitcnt == LAST_BYTE && more_words) begin
                cmd_valid <= 1'b1;
                cmd_we    <= 1'b0;
                cmd_addr  <= cur_addr + ADDR_INC;
              end
              if (bitcnt == LAST_WORD) begin
                bitcnt     <= '0;
                tx_sr      <= prefetch;
                cur_addr   <= cur_addr + ADDR_INC;
                words_done <= next_done[CNT_W-1:0];
              end
            end
          end
          default: ;
        endcase
      end else if (sclk_fall && state == ST_RD && bitcnt != '0) begin
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_bridge_busif.sv
module spi_bridge_busif #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (cmd_valid) begin
        bus_req   <= 1'b1;
        bus_we    <= cmd_we;
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_wdata;
      end else if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        if (!bus_we) begin
          rd_valid <= 1'b1;
          rd_data  <= bus_rdata;
        end
      end
    end
  end

endmodule

// File: rtl/spi_regbus_bridge.sv
module spi_regbus_bridge #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              err_clr,
  output logic              err_flag
);

  localparam int         N_PINS  = 3;
  localparam logic [2:0] RST_PAT = 3'b100;

  logic [N_PINS-1:0] pins_raw, pins_s;
  logic              cmd_valid, cmd_we, rd_valid, err_set;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata, rd_data;

  assign pins_raw = {spi_cs_n, spi_sclk, spi_mosi};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    spi_bridge_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(RST_PAT[g])
    ) u_sync (
      .clk (clk),
      .rst (rst),
      .din (pins_raw[g]),
      .dout(pins_s[g])
    );
  end

  spi_bridge_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[1]),
    .cs_n_s   (pins_s[2]),
    .mosi_s   (pins_s[0]),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .cmd_valid(cmd_valid),
    .cmd_we   (cmd_we),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .tx_bit   (spi_miso),
    .err_set  (err_set)
  );

  spi_bridge_busif #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_busif (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_we   (cmd_we),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_ack  (bus_ack)
  );

  always_ff @(posedge clk) begin
    if (rst)          err_flag <= 1'b0;
    else if (err_set) err_flag <= 1'b1;
    else if (err_clr) err_flag <= 1'b0;
  end

endmodule

// File: rtl/spi_bridge_chk.sv
module spi_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic              err_set,
  input logic              err_clr,
  input logic              err_flag
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req);

  // R9
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    err_set |=> err_flag);

  // R8
  err_clr_chk: assert property (@(posedge clk) disable iff (rst)
    err_clr && !err_set |=> !err_flag);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !err_set && !err_clr |=> $stable(err_flag));

  // R5
  rd_return_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_req && bus_ack && !bus_we));

endmodule

bind spi_regbus_bridge spi_bridge_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_ack  (bus_ack),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rd_valid (rd_valid),
  .err_set  (err_set),
  .err_clr  (err_clr),
  .err_flag (err_flag)
);

// File: tb/spi_regbus_bridge_test.sv
`timescale 1ns/100ps
module spi_regbus_bridge_test;

  localparam int HP = 50;

  logic        clk = 1'b0;
  logic        rst;
  logic        sclk, cs_n, mosi, miso;
  logic        bus_req, bus_we, bus_ack, err_clr, err_flag;
  logic [15:0] bus_addr, last_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;
  int txn    = 0;
  int viol   = 0;
  int lat    = 0;

  logic [31:0] regs  [64];
  logic [31:0] model [64];

  always #2.5 clk = ~clk;

  spi_regbus_bridge uut (
    .clk(clk), .rst(rst),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .err_clr(err_clr), .err_flag(err_flag)
  );

  function automatic logic [31:0] init_val(input int i);
    return 32'h5A000000 | (i * 32'h00010203);
  endfunction

  // register model behind the bus, random 1..3 cycle latency
  always @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      last_addr <= '0;
      lat       <= 0;
      for (int i = 0; i < 64; i++) regs[i] <= init_val(i);
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (lat == 0) begin
          bus_ack   <= 1'b1;
          last_addr <= bus_addr;
          txn       <= txn + 1;
          if (bus_we) regs[bus_addr[7:2]] <= bus_wdata;
          else        bus_rdata <= regs[bus_addr[7:2]];
          lat <= $urandom_range(0, 2);
        end else begin
          lat <= lat - 1;
        end
      end
    end
  end

  // R9 handshake monitor
  logic        pend_q = 1'b0;
  logic        we_q;
  logic [15:0] addr_q;
  logic [31:0] wd_q;
  always @(posedge clk) begin
    if (!rst && pend_q && (!bus_req || bus_we != we_q || bus_addr != addr_q || bus_wdata != wd_q))
      viol <= viol + 1;
    pend_q <= !rst && bus_req && !bus_ack;
    we_q   <= bus_we;
    addr_q <= bus_addr;
    wd_q   <= bus_wdata;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      #HP;
      rx[i] = miso;
      sclk = 1'b1;
      #HP;
      sclk = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [7:0] r;
    xfer_bits(b, 8, r);
  endtask

  task automatic frame_start();
    cs_n = 1'b0;
    #HP;
  endtask

  task automatic frame_stop();
    #HP;
    cs_n = 1'b1;
    #(HP * 6);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [15:0] a, input logic [7:0] n);
    send_byte(op);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    send_byte(n);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int k = 3; k >= 0; k--) send_byte(w[k*8 +: 8]);
  endtask

  task automatic recv_word(output logic [31:0] w);
    logic [7:0] r;
    for (int k = 3; k >= 0; k--) begin
      xfer_bits(8'h00, 8, r);
      w[k*8 +: 8] = r;
    end
  endtask

  task automatic clear_err();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    @(negedge clk);
  endtask

  logic [31:0] w, got;
  logic [15:0] base;
  logic [7:0]  rb;
  int          n, t0;

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000BEEF));
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; err_clr = 1'b0;
    for (int i = 0; i < 64; i++) model[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 err_flag after reset", {31'd0, err_flag}, 32'd0);
    check("R12 bus_req after reset", {31'd0, bus_req}, 32'd0);
    check("R12 miso after reset", {31'd0, miso}, 32'd0);

    // R1 R2 R3: single write, address with nonzero high byte
    w = 32'hC3A5_0F1E;
    t0 = txn;
    frame_start(); send_hdr(8'h61, 16'h12C4, 8'd1); send_word(w); frame_stop();
    model[49] = w;
    check("R1 R2 single write data", regs[49], model[49]);
    check("R3 full address high byte first", {16'd0, last_addr}, 32'h0000_12C4);
    check("R2 one write access", txn - t0, 1);
    check("R1 no error on good write", {31'd0, err_flag}, 32'd0);

    // R4: burst of three, address carries across the low byte
    t0 = txn;
    frame_start(); send_hdr(8'h61, 16'h20F8, 8'd3);
    for (int k = 0; k < 3; k++) begin
      w = $urandom;
      model[(8'hF8 >> 2) + k & 63] = w;
      send_word(w);
    end
    frame_stop();
    for (int k = 0; k < 3; k++)
      check("R4 burst write word", regs[(62 + k) & 63], model[(62 + k) & 63]);
    check("R4 last burst address", {16'd0, last_addr}, 32'h0000_2100);
    check("R4 burst access count", txn - t0, 3);

    // R5: single read
    frame_start(); send_hdr(8'h41, 16'h12C4, 8'd1); recv_word(got); frame_stop();
    check("R5 single read", got, model[49]);

    // constrained random mix of reads and writes
    for (int it = 0; it < 10; it++) begin
      base = 16'h0300 + 16'($urandom_range(0, 40) * 4);
      n    = $urandom_range(1, 5);
      t0   = txn;
      if ($urandom_range(0, 1) == 1) begin
        frame_start(); send_hdr(8'h61, base, 8'(n));
        for (int k = 0; k < n; k++) begin
          w = $urandom;
          model[(base[7:2] + k) & 63] = w;
          send_word(w);
        end
        frame_stop();
        for (int k = 0; k < n; k++)
          check("R4 random burst write", regs[(base[7:2] + k) & 63], model[(base[7:2] + k) & 63]);
      end else begin
        frame_start(); send_hdr(8'h41, base, 8'(n));
        for (int k = 0; k < n; k++) begin
          recv_word(got);
          check("R5 random burst read", got, model[(base[7:2] + k) & 63]);
        end
        frame_stop();
      end
      check("R4 random burst access count", txn - t0, n);
      check("R1 random frame no error", {31'd0, err_flag}, 32'd0);
    end

    // R6: chip select rises in the second word
    t0 = txn;
    frame_start(); send_hdr(8'h61, 16'h0080, 8'd2);
    send_word(32'h1111_2222); send_byte(8'h33); send_byte(8'h44);
    frame_stop();
    model[32] = 32'h1111_2222;
    check("R6 first word written", regs[32], model[32]);
    check("R6 incomplete word not written", regs[33], model[33]);
    check("R6 access count", txn - t0, 1);
    check("R6 error set on early end", {31'd0, err_flag}, 32'd1);
    clear_err();
    check("R8 error cleared", {31'd0, err_flag}, 32'd0);

    // R6: partial byte inside the header
    t0 = txn;
    frame_start(); send_byte(8'h41); send_byte(8'h00); send_byte(8'h10);
    xfer_bits(8'hA0, 3, rb);
    frame_stop();
    check("R6 partial byte error", {31'd0, err_flag}, 32'd1);
    check("R6 partial byte no access", txn - t0, 0);
    #(HP * 4);
    check("R8 error sticky", {31'd0, err_flag}, 32'd1);
    clear_err();

    // R7: unknown opcode
    t0 = txn;
    frame_start(); send_hdr(8'h55, 16'h0040, 8'd1); send_word(32'hDEAD_BEEF); frame_stop();
    check("R7 unknown opcode error", {31'd0, err_flag}, 32'd1);
    check("R7 unknown opcode no access", txn - t0, 0);
    check("R7 register untouched", regs[16], model[16]);
    clear_err();

    // R10: more words than declared
    t0 = txn;
    frame_start(); send_hdr(8'h61, 16'h0090, 8'd1);
    send_word(32'hABCD_0001); send_word(32'hABCD_0002);
    frame_stop();
    model[36] = 32'hABCD_0001;
    check("R10 declared word written", regs[36], model[36]);
    check("R10 extra word ignored", regs[37], model[37]);
    check("R10 access count", txn - t0, 1);
    check("R10 overrun error", {31'd0, err_flag}, 32'd1);
    clear_err();

    // R11: zero word count
    t0 = txn;
    frame_start(); send_hdr(8'h41, 16'h0010, 8'd0); frame_stop();
    frame_start(); send_hdr(8'h61, 16'h0010, 8'd0); frame_stop();
    check("R11 zero count no access", txn - t0, 0);
    check("R11 zero count no error", {31'd0, err_flag}, 32'd0);

    check("R9 handshake violations", viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule